// File: doc/BRIEF.md
# Tiled/Linear Pixel Transfer Engine

This block copies a two-dimensional image from one memory region to another. On the way it changes the layout between row-major (linear) order and 8x8-tiled order, and it converts the pixel format among five colour formats. It can halve the image in X, or in both X and Y, by box averaging, and it can mirror the result vertically. The surrounding logic sets up a configuration on the block's inputs and pulses `start`. The engine then reads source bytes and writes destination bytes through a single byte-wide memory port, one pixel at a time. When it finishes, or when it refuses the configuration, it returns to idle and raises a one-cycle `done` pulse.

A tiled image is stored as 8-row bands. Inside a band, each column of 8x8 tiles occupies 64 consecutive pixels, and within a tile the pixel index interleaves the coordinate bits. The engine computes source coordinates from the output coordinates and the scale first, and applies the vertical mirror afterwards, to the destination row only.

Top module: `tile_xfer_engine`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `mem_re` and `mem_we` are all low.
- R2: Format codes and their bytes per pixel are 0 = 32-bit RGBA (4), 1 = 24-bit RGB (3), 2 = RGB 5-6-5 (2), 3 = RGB 5-5-5 with 1-bit alpha (2) and 4 = 4-bit RGBA (2). Pixels are little-endian in memory. In the 32-bit format, red is bits 31:24, green 23:16, blue 15:8 and alpha 7:0. In the 24-bit format, red is 23:16, green 15:8 and blue 7:0. In 5-6-5, red is 15:11, green 10:5 and blue 4:0. In 5-5-5-1, red is 15:11, green 10:6, blue 5:1 and alpha is bit 0. In 4-bit RGBA, red is 15:12, green 11:8, blue 7:4 and alpha 3:0. A format with no alpha field reads as alpha 255.
- R3: When a narrow field is widened to 8 bits, its top bits are repeated into the low bits. A 1-bit alpha becomes 0 or 255. When a channel is narrowed, its low bits are dropped. A 1-bit alpha takes bit 7 of the 8-bit alpha.
- R4: The source is tiled unless `in_linear` is set. With `no_swizzle` low, the destination uses the other layout from the source. With `no_swizzle` high, the destination uses the same layout as the source.
- R5: The tiled pixel index of (x, y) is (x div 8)·64, plus the interleave of bits x0, y0, x1, y1, x2, y2 (from bit 0 upward), plus (y with its low 3 bits cleared)·width. The byte offset is this index times bytes per pixel.
- R6: The linear byte offset is (x + y·width)·bytes per pixel. The source uses the input width. The destination uses the effective output width.
- R7: Scale mode 0 leaves the sizes unchanged. Mode 1 halves the output width. Mode 2 halves both output width and height. The source coordinates are the output coordinates shifted left by the per-axis scale.
- R8: Mode 1 averages the addressed source pixel with the next pixel in memory. Mode 2 averages it with the next three. Both divide per channel and truncate.
- R9: With `flip_v` set, output row y is stored at destination row (effective height − 1 − y), while the source row still comes from y.
- R10: The engine rejects a transfer if any of these holds: a dimension is zero; an effective output dimension is zero; the scale mode is 3; scaling is requested with linear input; a format code is above 4. A rejected transfer makes no memory write and ends with `err` high during `done`.
- R11: Completion gives exactly one `done` pulse, and `busy` is low in the following cycle. `err` is never high without `done`.
- R12: A `start` pulse while `busy` is high is ignored.
- R13: Read data appears on `mem_rdata` one cycle after `mem_re`. The engine never reads and writes in the same cycle. It writes output pixels in raster order of the output loop, with the bytes of each pixel in ascending address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (sampled when idle) |
| src_base | input | AW | Source byte address |
| dst_base | input | AW | Destination byte address |
| in_w | input | DW | Source width in pixels |
| in_h | input | DW | Source height in pixels |
| out_w | input | DW | Destination width before scaling |
| out_h | input | DW | Destination height before scaling |
| in_fmt | input | 3 | Source format code |
| out_fmt | input | 3 | Destination format code |
| in_linear | input | 1 | Source is row-major |
| no_swizzle | input | 1 | Keep the source layout on the destination |
| flip_v | input | 1 | Mirror rows on the destination |
| scale_mode | input | 2 | 0 none, 1 X, 2 X and Y |
| busy | output | 1 | Transfer accepted and not yet finished |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | High with `done` when the transfer was rejected |
| mem_re | output | 1 | Byte read request |
| mem_we | output | 1 | Byte write request |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, one cycle after `mem_re` |

## Verification
The bench builds the engine with AW = 13 and DW = 8. An 8 KiB byte space then holds a 16x16 32-bit source and a separate destination area without aliasing. Images 16 pixels wide and high cross tile boundaries in both axes, so both the coarse-column term and the band term of the tiled address are exercised. DW = 8 still leaves room for the flip and halving arithmetic, so every layout pairing, every scale mode and every rejection case is reachable within a short run.

// File: rtl/tile_xfer_pkg.sv
package tile_xfer_pkg;

   localparam logic [2:0] FMT_RGBA8  = 3'd0;
   localparam logic [2:0] FMT_RGB8   = 3'd1;
   localparam logic [2:0] FMT_RGB565 = 3'd2;
   localparam logic [2:0] FMT_RGB5A1 = 3'd3;
   localparam logic [2:0] FMT_RGBA4  = 3'd4;

   localparam logic [1:0] SC_NONE = 2'd0;
   localparam logic [1:0] SC_X    = 2'd1;
   localparam logic [1:0] SC_XY   = 2'd2;

   typedef struct packed {
      logic [7:0] r;
      logic [7:0] g;
      logic [7:0] b;
      logic [7:0] a;
   } rgba_t;

   function automatic logic [2:0] fmt_bytes(input logic [2:0] f);
      case (f)
         FMT_RGBA8: return 3'd4;
         FMT_RGB8:  return 3'd3;
         default:   return 3'd2;
      endcase
   endfunction

   function automatic logic fmt_known(input logic [2:0] f);
      return f <= FMT_RGBA4;
   endfunction

   function automatic logic [7:0] widen5(input logic [4:0] v);
      return {v, v[4:2]};
   endfunction

   function automatic logic [7:0] widen6(input logic [5:0] v);
      return {v, v[5:4]};
   endfunction

   function automatic logic [7:0] widen4(input logic [3:0] v);
      return {v, v};
   endfunction

endpackage

// File: rtl/tile_xfer_offset.sv
module tile_xfer_offset
   import tile_xfer_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 10
) (
   input  logic [DW-1:0] x,
   input  logic [DW-1:0] y,
   input  logic [DW-1:0] width,
   input  logic [2:0]    bpp,
   input  logic          tiled,
   output logic [AW-1:0] off
);
   localparam int MW = DW + 3;

   logic [MW-1:0] morton;
   logic [DW-1:0] band_row;
   logic [AW-1:0] pix_idx;

   always_comb begin
      morton   = {x[DW-1:3], y[2], x[2], y[1], x[1], y[0], x[0]};
      band_row = {y[DW-1:3], 3'b000};
      if (tiled)
         pix_idx = AW'(morton) + AW'(band_row) * AW'(width);
      else
         pix_idx = AW'(x) + AW'(y) * AW'(width);
      off = pix_idx * AW'(bpp);
   end

endmodule

// File: rtl/tile_xfer_unpack.sv
module tile_xfer_unpack
   import tile_xfer_pkg::*;
(
   input  logic [31:0] raw,
   input  logic [2:0]  fmt,
   output rgba_t       px
);
   always_comb begin
      px = '0;
      case (fmt)
         FMT_RGBA8: px = '{r: raw[31:24], g: raw[23:16], b: raw[15:8], a: raw[7:0]};
         FMT_RGB8:  px = '{r: raw[23:16], g: raw[15:8], b: raw[7:0], a: 8'hFF};
         FMT_RGB565: px = '{r: widen5(raw[15:11]), g: widen6(raw[10:5]),
                            b: widen5(raw[4:0]), a: 8'hFF};
         FMT_RGB5A1: px = '{r: widen5(raw[15:11]), g: widen5(raw[10:6]),
                            b: widen5(raw[5:1]), a: {8{raw[0]}}};
         FMT_RGBA4: px = '{r: widen4(raw[15:12]), g: widen4(raw[11:8]),
                           b: widen4(raw[7:4]), a: widen4(raw[3:0])};
         default:   px = '0;
      endcase
   end
endmodule

// File: rtl/tile_xfer_pack.sv
module tile_xfer_pack
   import tile_xfer_pkg::*;
(
   input  rgba_t       px,
   input  logic [2:0]  fmt,
   output logic [31:0] raw
);
   always_comb begin
      case (fmt)
         FMT_RGBA8:  raw = {px.r, px.g, px.b, px.a};
         FMT_RGB8:   raw = {8'h00, px.r, px.g, px.b};
         FMT_RGB565: raw = {16'h0, px.r[7:3], px.g[7:2], px.b[7:3]};
         FMT_RGB5A1: raw = {16'h0, px.r[7:3], px.g[7:3], px.b[7:3], px.a[7]};
         FMT_RGBA4:  raw = {16'h0, px.r[7:4], px.g[7:4], px.b[7:4], px.a[7:4]};
         default:    raw = '0;
      endcase
   end
endmodule

// File: rtl/tile_xfer_engine.sv
module tile_xfer_engine
   import tile_xfer_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] src_base,
   input  logic [AW-1:0] dst_base,
   input  logic [DW-1:0] in_w,
   input  logic [DW-1:0] in_h,
   input  logic [DW-1:0] out_w,
   input  logic [DW-1:0] out_h,
   input  logic [2:0]    in_fmt,
   input  logic [2:0]    out_fmt,
   input  logic          in_linear,
   input  logic          no_swizzle,
   input  logic          flip_v,
   input  logic [1:0]    scale_mode,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic          mem_re,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_wdata,
   input  logic [7:0]    mem_rdata
);
   localparam int NPIX = 4;              // widest box footprint
   localparam int BUFB = NPIX * 4;       // bytes held for one footprint
   localparam int BIW  = $clog2(BUFB);
   localparam int CW   = BIW + 1;

   generate
      if (DW < 4) begin : g_dw_chk
         $error("DW must be at least 4 to hold a tile coordinate");
      end
      if (AW < DW + 4) begin : g_aw_chk
         $error("AW must exceed DW by at least 4");
      end
   endgenerate

   typedef enum logic [2:0] {
      S_IDLE, S_CHECK, S_ADDR, S_READ, S_DRAIN, S_CALC, S_WRITE, S_FIN
   } st_e;

   st_e state;

   // latched configuration
   logic [AW-1:0] c_src, c_dst;
   logic [DW-1:0] c_iw, c_ih, c_ow, c_oh;
   logic [2:0]    c_ifmt, c_ofmt;
   logic          c_lin, c_nosw, c_flip;
   logic [1:0]    c_sc;

   // derived at check time
   logic [DW-1:0] ow_e, oh_e;
   logic          hs, vs;
   logic [2:0]    ibpp, obpp;
   logic [CW-1:0] rd_last;
   logic          err_r;

   // walk state
   logic [DW-1:0] ox, oy;
   logic [AW-1:0] src_a, dst_a;
   logic [BIW-1:0] rd_cnt;
   logic [1:0]    wr_cnt;
   logic [31:0]   wword;
   logic          cap_v;
   logic [BIW-1:0] cap_idx;
   logic [7:0]    rbuf [BUFB];

   // ---------------- check stage ----------------
   logic          hs_c, vs_c, bad_c;
   logic [DW-1:0] ow_c, oh_c;
   logic [1:0]    sh_c;
   logic [CW-1:0] nbytes_c;

   always_comb begin
      hs_c     = c_sc != SC_NONE;
      vs_c     = c_sc == SC_XY;
      ow_c     = c_ow >> hs_c;
      oh_c     = c_oh >> vs_c;
      sh_c     = {1'b0, hs_c} + {1'b0, vs_c};
      nbytes_c = CW'(fmt_bytes(c_ifmt)) << sh_c;
      bad_c    = (c_iw == '0) || (c_ih == '0) || (c_ow == '0) || (c_oh == '0) ||
                 (ow_c == '0) || (oh_c == '0) || (c_sc == 2'd3) ||
                 (c_lin && (c_sc != SC_NONE)) ||
                 !fmt_known(c_ifmt) || !fmt_known(c_ofmt);
   end

   // ---------------- address stage ----------------
   logic [DW-1:0] sx, sy, dy;
   logic [AW-1:0] soff, doff;

   always_comb begin
      sx = ox << hs;
      sy = oy << vs;
      dy = c_flip ? (oh_e - DW'(1) - oy) : oy;
   end

   tile_xfer_offset #(.AW(AW), .DW(DW)) u_src_off (
      .x(sx), .y(sy), .width(c_iw), .bpp(ibpp), .tiled(!c_lin), .off(soff)
   );

   tile_xfer_offset #(.AW(AW), .DW(DW)) u_dst_off (
      .x(ox), .y(dy), .width(ow_e), .bpp(obpp), .tiled(c_lin ^ c_nosw), .off(doff)
   );

   // ---------------- decode and average ----------------
   rgba_t         pxs [NPIX];
   rgba_t         avg_px;
   logic [31:0]   out_raw;
   logic [1:0]    sh;

   assign sh = {1'b0, hs} + {1'b0, vs};

   generate
      for (genvar k = 0; k < NPIX; k++) begin : g_unpack
         logic [BIW-1:0] base;
         logic [31:0]    raw;
         always_comb begin
            base = BIW'(k) * BIW'(ibpp);
            raw  = {rbuf[BIW'(base + BIW'(3))], rbuf[BIW'(base + BIW'(2))],
                    rbuf[BIW'(base + BIW'(1))], rbuf[base]};
         end
         tile_xfer_unpack u_unpack (.raw(raw), .fmt(c_ifmt), .px(pxs[k]));
      end
   endgenerate

   always_comb begin
      logic [9:0] sr, sg, sb, sa;
      sr = '0; sg = '0; sb = '0; sa = '0;
      for (int k = 0; k < NPIX; k++) begin
         if (k < (1 << sh)) begin
            sr = sr + 10'(pxs[k].r);
            sg = sg + 10'(pxs[k].g);
            sb = sb + 10'(pxs[k].b);
            sa = sa + 10'(pxs[k].a);
         end
      end
      avg_px.r = 8'(sr >> sh);
      avg_px.g = 8'(sg >> sh);
      avg_px.b = 8'(sb >> sh);
      avg_px.a = 8'(sa >> sh);
   end

   tile_xfer_pack u_pack (.px(avg_px), .fmt(c_ofmt), .raw(out_raw));

   // ---------------- sequencer ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         c_src   <= '0; c_dst <= '0;
         c_iw    <= '0; c_ih <= '0; c_ow <= '0; c_oh <= '0;
         c_ifmt  <= '0; c_ofmt <= '0;
         c_lin   <= 1'b0; c_nosw <= 1'b0; c_flip <= 1'b0; c_sc <= '0;
         ow_e    <= '0; oh_e <= '0; hs <= 1'b0; vs <= 1'b0;
         ibpp    <= '0; obpp <= '0; rd_last <= '0; err_r <= 1'b0;
         ox      <= '0; oy <= '0; src_a <= '0; dst_a <= '0;
         rd_cnt  <= '0; wr_cnt <= '0; wword <= '0;
         cap_v   <= 1'b0; cap_idx <= '0;
      end else begin
         cap_v   <= (state == S_READ);
         cap_idx <= rd_cnt;
         case (state)
            S_IDLE: if (start) begin
               c_src  <= src_base;  c_dst  <= dst_base;
               c_iw   <= in_w;      c_ih   <= in_h;
               c_ow   <= out_w;     c_oh   <= out_h;
               c_ifmt <= in_fmt;    c_ofmt <= out_fmt;
               c_lin  <= in_linear; c_nosw <= no_swizzle;
               c_flip <= flip_v;    c_sc   <= scale_mode;
               err_r  <= 1'b0;
               state  <= S_CHECK;
            end
            S_CHECK: begin
               ow_e    <= ow_c;
               oh_e    <= oh_c;
               hs      <= hs_c;
               vs      <= vs_c;
               ibpp    <= fmt_bytes(c_ifmt);
               obpp    <= fmt_bytes(c_ofmt);
               rd_last <= nbytes_c - CW'(1);
               ox      <= '0;
               oy      <= '0;
               if (bad_c) begin
                  err_r <= 1'b1;
                  state <= S_FIN;
               end else begin
                  state <= S_ADDR;
               end
            end
            S_ADDR: begin
               src_a  <= c_src + soff;
               dst_a  <= c_dst + doff;
               rd_cnt <= '0;
               state  <= S_READ;
            end
            S_READ: begin
               rd_cnt <= rd_cnt + BIW'(1);
               if ({1'b0, rd_cnt} == rd_last) state <= S_DRAIN;
            end
            S_DRAIN: state <= S_CALC;
            S_CALC: begin
               wword  <= out_raw;
               wr_cnt <= '0;
               state  <= S_WRITE;
            end
            S_WRITE: begin
               wr_cnt <= wr_cnt + 2'd1;
               if (3'(wr_cnt) == obpp - 3'd1) begin
                  if (ox == ow_e - DW'(1)) begin
                     ox <= '0;
                     if (oy == oh_e - DW'(1)) begin
                        state <= S_FIN;
                     end else begin
                        oy    <= oy + DW'(1);
                        state <= S_ADDR;
                     end
                  end else begin
                     ox    <= ox + DW'(1);
                     state <= S_ADDR;
                  end
               end
            end
            S_FIN:   state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (cap_v) rbuf[cap_idx] <= mem_rdata;
   end

   // ---------------- port outputs ----------------
   always_comb begin
      busy      = state != S_IDLE;
      done      = state == S_FIN;
      err       = done && err_r;
      mem_re    = state == S_READ;
      mem_we    = state == S_WRITE;
      mem_wdata = wword[8*wr_cnt +: 8];
      if (state == S_READ)       mem_addr = src_a + AW'(rd_cnt);
      else if (state == S_WRITE) mem_addr = dst_a + AW'(wr_cnt);
      else                       mem_addr = '0;
   end

   // ---------------- checks ----------------
   logic wrote_any;
   always_ff @(posedge clk) begin
      if (!rst_n)                        wrote_any <= 1'b0;
      else if (state == S_IDLE && start) wrote_any <= 1'b0;
      else if (mem_we)                   wrote_any <= 1'b1;
   end

   assert_err_needs_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   assert_reject_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !wrote_any);

   assert_done_then_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   assert_port_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_re, mem_we}));

   assert_busy_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

endmodule

// File: tb/tile_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module tile_xfer_engine_tb_top;
   localparam int AW = 13;
   localparam int DW = 8;
   localparam int MEMSZ = 1 << AW;
   localparam int SRC = 0;
   localparam int DST = 'h1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          start = 1'b0;
   logic [AW-1:0] src_base = AW'(SRC), dst_base = AW'(DST);
   logic [DW-1:0] in_w = '0, in_h = '0, out_w = '0, out_h = '0;
   logic [2:0]    in_fmt = '0, out_fmt = '0;
   logic          in_linear = 1'b0, no_swizzle = 1'b0, flip_v = 1'b0;
   logic [1:0]    scale_mode = '0;
   logic          busy, done, err, mem_re, mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;
   logic [7:0]    mem_rdata = '0;

   tile_xfer_engine #(.AW(AW), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .src_base(src_base), .dst_base(dst_base),
      .in_w(in_w), .in_h(in_h), .out_w(out_w), .out_h(out_h),
      .in_fmt(in_fmt), .out_fmt(out_fmt),
      .in_linear(in_linear), .no_swizzle(no_swizzle), .flip_v(flip_v),
      .scale_mode(scale_mode),
      .busy(busy), .done(done), .err(err),
      .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   int ntot = 0;
   int nbad = 0;
   string cur_tag = "R1";
   logic [AW+7:0] expq [$];
   logic [7:0] mem [MEMSZ];

   // byte memory, read data one cycle after request (R13)
   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr];
   end

   task automatic check(input bit ok, input string what, input int act, input int exp);
      ntot++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_re && mem_we) check(1'b0, "R13 read and write together", 1, 0);
         if (mem_we) begin
            if (expq.size() == 0) begin
               check(1'b0, {cur_tag, " unexpected write"}, int'(mem_addr), 0);
            end else begin
               logic [AW+7:0] e;
               e = expq.pop_front();
               check({mem_addr, mem_wdata} == e, {cur_tag, " write addr/data"},
                     int'({mem_addr, mem_wdata}), int'(e));
            end
         end
      end
   end

   // ---------------- reference model ----------------
   function automatic int bpp_of(input int f);
      return (f == 0) ? 4 : (f == 1) ? 3 : 2;
   endfunction

   function automatic int pos_of(input int x, input int y, input int w,
                                 input int bpp, input bit tiled);
      int inter;
      if (!tiled) return (x + y * w) * bpp;
      inter = (x & 1) | ((y & 1) << 1) | ((x & 2) << 1) | ((y & 2) << 2) |
              ((x & 4) << 2) | ((y & 4) << 3);
      return ((x >> 3) * 64 + inter + (y & ~7) * w) * bpp;
   endfunction

   function automatic void decode(input int f, input int raw, output int c[4]);
      int v;
      case (f)
         0: begin c[0] = (raw >> 24) & 255; c[1] = (raw >> 16) & 255;
                  c[2] = (raw >> 8) & 255;  c[3] = raw & 255; end
         1: begin c[0] = (raw >> 16) & 255; c[1] = (raw >> 8) & 255;
                  c[2] = raw & 255; c[3] = 255; end
         2: begin
            v = (raw >> 11) & 31; c[0] = (v << 3) | (v >> 2);
            v = (raw >> 5) & 63;  c[1] = (v << 2) | (v >> 4);
            v = raw & 31;         c[2] = (v << 3) | (v >> 2);
            c[3] = 255;
         end
         3: begin
            v = (raw >> 11) & 31; c[0] = (v << 3) | (v >> 2);
            v = (raw >> 6) & 31;  c[1] = (v << 3) | (v >> 2);
            v = (raw >> 1) & 31;  c[2] = (v << 3) | (v >> 2);
            c[3] = (raw & 1) ? 255 : 0;
         end
         default: begin
            c[0] = ((raw >> 12) & 15) * 17; c[1] = ((raw >> 8) & 15) * 17;
            c[2] = ((raw >> 4) & 15) * 17;  c[3] = (raw & 15) * 17;
         end
      endcase
   endfunction

   function automatic int encode(input int f, input int c[4]);
      case (f)
         0: return (c[0] << 24) | (c[1] << 16) | (c[2] << 8) | c[3];
         1: return (c[0] << 16) | (c[1] << 8) | c[2];
         2: return ((c[0] >> 3) << 11) | ((c[1] >> 2) << 5) | (c[2] >> 3);
         3: return ((c[0] >> 3) << 11) | ((c[1] >> 3) << 6) | ((c[2] >> 3) << 1) | (c[3] >> 7);
         default: return ((c[0] >> 4) << 12) | ((c[1] >> 4) << 8) | ((c[2] >> 4) << 4) | (c[3] >> 4);
      endcase
   endfunction

   task automatic model(input int iw, input int ow, input int oh, input int ifm,
                        input int ofm, input bit lin, input bit nosw, input bit flp,
                        input int sc);
      int hsh, vsh, owe, ohe, ib, ob, n;
      hsh = (sc != 0) ? 1 : 0;
      vsh = (sc == 2) ? 1 : 0;
      owe = ow >> hsh;
      ohe = oh >> vsh;
      ib = bpp_of(ifm);
      ob = bpp_of(ofm);
      n = 1 << (hsh + vsh);
      for (int y = 0; y < ohe; y++) begin
         for (int x = 0; x < owe; x++) begin
            int so, dofs, dy, outv;
            int sum[4];
            int px[4];
            dy = flp ? (ohe - 1 - y) : y;
            so = SRC + pos_of(x << hsh, y << vsh, iw, ib, !lin);
            dofs = DST + pos_of(x, dy, owe, ob, lin ^ nosw);
            for (int c = 0; c < 4; c++) sum[c] = 0;
            for (int k = 0; k < n; k++) begin
               int raw;
               raw = 0;
               for (int b = 0; b < ib; b++)
                  raw = raw | (int'(mem[(so + k * ib + b) % MEMSZ]) << (8 * b));
               decode(ifm, raw, px);
               for (int c = 0; c < 4; c++) sum[c] += px[c];
            end
            for (int c = 0; c < 4; c++) px[c] = sum[c] / n;
            outv = encode(ofm, px);
            for (int b = 0; b < ob; b++)
               expq.push_back({AW'(dofs + b), 8'((outv >> (8 * b)) & 255)});
         end
      end
   endtask

   // ---------------- driver ----------------
   task automatic xfer(input string tag, input int iw, input int ih, input int ow,
                       input int oh, input int ifm, input int ofm, input bit lin,
                       input bit nosw, input bit flp, input int sc, input bit rej,
                       input bit poke);
      int dones;
      cur_tag = tag;
      @(negedge clk);
      in_w = DW'(iw); in_h = DW'(ih); out_w = DW'(ow); out_h = DW'(oh);
      in_fmt = 3'(ifm); out_fmt = 3'(ofm);
      in_linear = lin; no_swizzle = nosw; flip_v = flp; scale_mode = 2'(sc);
      if (!rej) model(iw, ow, oh, ifm, ofm, lin, nosw, flp, sc);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, {tag, " R11 busy after start"}, busy, 1);
      if (poke) begin
         // R12: a second start with a rejectable setup while busy
         repeat (40) @(negedge clk);
         in_w = '0;
         scale_mode = 2'd3;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      dones = 0;
      while (done !== 1'b1) @(negedge clk);
      dones++;
      check(err == rej, {tag, " R10 err at done"}, err, rej);
      check(expq.size() == 0, {tag, " R13 all writes seen"}, expq.size(), 0);
      @(negedge clk);
      check(busy == 1'b0 && done == 1'b0, {tag, " R11 idle after done"}, {busy, done}, 0);
      repeat (3) begin
         @(negedge clk);
         if (done) dones++;
      end
      check(dones == 1 && busy == 1'b0, {tag, " R12 single completion"}, dones, 1);
      expq.delete();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      ntot++;
      nbad++;
      $display("FAIL R11 watchdog: actual=no_done expected=done");
      $display("  test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
   end

   initial begin
      for (int i = 0; i < MEMSZ; i++)
         mem[i] = 8'(((i * 73) + ((i >> 5) * 29) + 7) ^ (i >> 2));
      repeat (3) @(negedge clk);
      // R1 reset state
      check(busy == 0 && done == 0 && err == 0 && mem_re == 0 && mem_we == 0,
            "R1 reset outputs", {busy, done, err, mem_re, mem_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 0 && mem_we == 0, "R1 idle after reset", {busy, mem_we}, 0);

      // tiled -> linear, 32-bit -> 24-bit (R2 R4 R5 R6)
      xfer("R2 R4 R5 tiled-to-linear", 16, 16, 16, 16, 0, 1, 0, 0, 0, 0, 0, 0);
      // linear -> tiled, 5-6-5 -> 32-bit, flipped (R3 R4 R6 R9)
      xfer("R3 R6 R9 linear-to-tiled flip", 16, 8, 16, 8, 2, 0, 1, 0, 1, 0, 0, 0);
      // tiled -> tiled, 5-5-5-1 -> 4-bit, X halving (R3 R7 R8)
      xfer("R7 R8 tiled-to-tiled halfX", 16, 8, 16, 8, 3, 4, 0, 1, 0, 1, 0, 0);
      // tiled -> linear, 4-bit -> 5-6-5, XY halving, flipped (R7 R8 R9)
      xfer("R8 R9 halfXY flip", 16, 16, 16, 16, 4, 2, 0, 0, 1, 2, 0, 0);
      // full precision XY average (R8)
      xfer("R8 halfXY 32-bit", 16, 16, 16, 16, 0, 0, 0, 0, 0, 2, 0, 0);
      // linear -> linear, 24-bit -> 5-5-5-1 (R3 R4 R6)
      xfer("R4 R6 linear-to-linear", 8, 8, 8, 8, 1, 3, 1, 1, 0, 0, 0, 0);
      // start while busy is ignored (R12)
      xfer("R12 start while busy", 8, 8, 8, 8, 0, 2, 0, 0, 0, 0, 0, 1);
      // rejections (R10)
      xfer("R10 zero input width", 0, 8, 8, 8, 0, 0, 0, 0, 0, 0, 1, 0);
      xfer("R10 zero output height", 8, 8, 8, 0, 0, 0, 0, 0, 0, 0, 1, 0);
      xfer("R10 scale mode 3", 8, 8, 8, 8, 0, 0, 0, 0, 0, 3, 1, 0);
      xfer("R10 linear input scaled", 8, 8, 8, 8, 0, 0, 1, 0, 0, 1, 1, 0);
      xfer("R10 unknown format", 8, 8, 8, 8, 0, 5, 0, 0, 0, 0, 1, 0);
      xfer("R10 effective width zero", 8, 8, 1, 8, 0, 0, 0, 0, 0, 1, 1, 0);
      // accepted again after rejections (R10 R11)
      xfer("R5 R11 recovery", 8, 8, 8, 8, 2, 2, 0, 1, 0, 0, 0, 0);

      $display("  test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
   end
endmodule